// File: doc/BRIEF.md
# Integration Test Register Bank

This block holds three small registers that let test software take control of a peripheral's pins and internal signals during chip integration. One control bit, the test enable, moves a set of multiplexers off their functional sources and onto values held in the registers. Software can then drive the peripheral's pad outputs and its chip-internal outputs (DMA requests and interrupts), force the internal DMA-clear input, and read back the pad inputs and the multiplexer outputs.

The control register also carries four mode fields (two pad-enable controls, a register-test bit and a two-bit FIFO-test field). These fields are brought out as ports for the peripheral core to decode. The bank is reached over a simple register bus: address, write strobe, write data, read strobe and read data. The read data is registered.

Bits read back from different places. A chip-internal bit returns the live value at its multiplexer output. A pad-output bit returns only the value that was written.

Top module: `itest_regbank`

## Requirements
- R1: After reset the control register reads 0x30, with `cmd_pad_en` and `dat_pad_en` at 1 and every other control output at 0. The input and output test registers hold 0.
- R2: The control register sits at offset 0x100 and stores write data bits 5:0. The field layout is: bit 0 `test_en`, bits 2:1 `fifo_test_mode`, bit 3 `reg_test_mode`, bit 4 `cmd_pad_en`, bit 5 `dat_pad_en`. Bits above 5 read as 0.
- R3: The input test register sits at offset 0x104, and only its bit 0 is stored. While `test_en` is 1, `dmaclr_int` follows the stored bit. While `test_en` is 0, it follows `dmaclr_ext`.
- R4: Bit 0 of a read of offset 0x104 returns the current value of `dmaclr_int` (the multiplexer output), not the stored bit.
- R5: Bit 5 of a read of offset 0x104 returns `cmd_in_pin` and bit 1 returns `dat_in_pin`. All other bits of that register read 0, and writes to them have no effect.
- R6: The output test register sits at offset 0x108. Bits 11, 10 and 6 drive `power_pin`, `cmd_out_pin` and `dat_out_pin` while `test_en` is 1. Reads of these bits return the stored value whatever `test_en` is.
- R7: Output test bits 5:0 drive `intra_out[5:0]` while `test_en` is 1. In order from bit 5 down to bit 0 they are: last-burst DMA request, last-single DMA request, burst DMA request, single DMA request, interrupt 1, interrupt 0. Reads of bits 5:0 return `intra_out`. Bits 9:7 read 0.
- R8: While `test_en` is 0, every covered output follows its functional source. The stored output test values are kept and take effect again when `test_en` returns to 1.
- R9: A read of any offset other than the three above returns 0. A write to such an offset changes no register.
- R10: `bus_rdata` presents the addressed value in the cycle after `bus_rd` is sampled high, and is 0 after any cycle with `bus_rd` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| test_en | output | 1 | Integration test enable |
| fifo_test_mode | output | 2 | FIFO test field for the core |
| reg_test_mode | output | 1 | Register test bit for the core |
| cmd_pad_en | output | 1 | Command pad enable control |
| dat_pad_en | output | 1 | Data pad enable control |
| dmaclr_ext | input | 1 | DMA-clear input from the chip |
| dmaclr_int | output | 1 | DMA-clear input as seen by the core |
| cmd_in_pin | input | 1 | Command input pad |
| dat_in_pin | input | 1 | Data input pad |
| fn_intra | input | 6 | Functional chip-internal outputs from the core |
| intra_out | output | 6 | Chip-internal outputs after the test multiplexers |
| fn_power | input | 1 | Functional power control |
| fn_cmd_out | input | 1 | Functional command output |
| fn_dat_out | input | 1 | Functional data output |
| power_pin | output | 1 | Power control pad |
| cmd_out_pin | output | 1 | Command output pad |
| dat_out_pin | output | 1 | Data output pad |

## Verification
The bench builds the block with its default parameters: a 12-bit address and 32-bit data.

- The full 12-bit offset space is reachable, so reads and writes to neighbouring unmapped offsets (0x000, 0x10C, 0x200) are checked against aliasing onto the three registers.
- The 32-bit data width makes it possible to write all-ones patterns and confirm that reserved and upper bits read back as 0.
- Because functional sources and register values are driven with opposite patterns, each readback shows clearly which source it came from.

// File: rtl/itr_pkg.sv
package itr_pkg;

    localparam int CTRL_W  = 6;
    localparam int IN_W    = 6;
    localparam int OUT_W   = 12;
    localparam int INTRA_N = 6;

    localparam int IN_CLR_BIT  = 0;
    localparam int IN_DAT_BIT  = 1;
    localparam int IN_CMD_BIT  = 5;
    localparam int OUT_DAT_BIT = 6;
    localparam int OUT_CMD_BIT = 10;
    localparam int OUT_PWR_BIT = 11;

    typedef struct packed {
        logic       dat_pad_en;
        logic       cmd_pad_en;
        logic       reg_test;
        logic [1:0] fifo_test;
        logic       test_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = ctrl_t'(6'b110000);

    typedef struct packed {
        logic power;
        logic cmd_out;
        logic dat_out;
    } prim_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_IN,
        SEL_OUT
    } regsel_e;

    function automatic logic [OUT_W-1:0] pack_out(prim_t p, logic [INTRA_N-1:0] intra);
        logic [OUT_W-1:0] w;
        w = '0;
        w[OUT_PWR_BIT] = p.power;
        w[OUT_CMD_BIT] = p.cmd_out;
        w[OUT_DAT_BIT] = p.dat_out;
        w[INTRA_N-1:0] = intra;
        return w;
    endfunction

    function automatic prim_t unpack_prim(logic [OUT_W-1:0] w);
        prim_t p;
        p.power   = w[OUT_PWR_BIT];
        p.cmd_out = w[OUT_CMD_BIT];
        p.dat_out = w[OUT_DAT_BIT];
        return p;
    endfunction

    function automatic logic [IN_W-1:0] pack_in(logic clr, logic cmd, logic dat);
        logic [IN_W-1:0] w;
        w = '0;
        w[IN_CLR_BIT] = clr;
        w[IN_CMD_BIT] = cmd;
        w[IN_DAT_BIT] = dat;
        return w;
    endfunction

endpackage

// File: rtl/itest_ctrl_reg.sv
module itest_ctrl_reg
    import itr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= CTRL_RST;
        end else if (we) begin
            q <= ctrl_t'(wdata);
        end
    end

endmodule

// File: rtl/itest_in_path.sv
module itest_in_path
    import itr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic            wbit,
    input  logic            test_en,
    input  logic            clr_ext,
    input  logic            cmd_pin,
    input  logic            dat_pin,
    output logic            clr_int,
    output logic [IN_W-1:0] rd_val
);

    logic clr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_q <= 1'b0;
        end else if (we) begin
            clr_q <= wbit;
        end
    end

    assign clr_int = test_en ? clr_q : clr_ext;
    assign rd_val  = pack_in(clr_int, cmd_pin, dat_pin);

endmodule

// File: rtl/itest_out_path.sv
module itest_out_path
    import itr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [OUT_W-1:0]   wdata,
    input  logic               test_en,
    input  logic [INTRA_N-1:0] fn_intra,
    input  prim_t              fn_prim,
    output logic [INTRA_N-1:0] intra_out,
    output prim_t              prim_out,
    output logic [OUT_W-1:0]   rd_val
);

    prim_t              prim_q;
    logic [INTRA_N-1:0] intra_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prim_q  <= '0;
            intra_q <= '0;
        end else if (we) begin
            prim_q  <= unpack_prim(wdata);
            intra_q <= wdata[INTRA_N-1:0];
        end
    end

    // One test multiplexer per chip-internal line
    for (genvar i = 0; i < INTRA_N; i++) begin : g_intra_mux
        assign intra_out[i] = test_en ? intra_q[i] : fn_intra[i];
    end

    assign prim_out = test_en ? prim_q : fn_prim;

    // Pad bits report the stored value, internal bits the live mux output
    assign rd_val = pack_out(prim_q, intra_out);

endmodule

// File: rtl/itest_regbank.sv
module itest_regbank
    import itr_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int CTRL_OFS = 'h100,
    parameter int IN_OFS   = 'h104,
    parameter int OUT_OFS  = 'h108
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              test_en,
    output logic [1:0]        fifo_test_mode,
    output logic              reg_test_mode,
    output logic              cmd_pad_en,
    output logic              dat_pad_en,
    input  logic              dmaclr_ext,
    output logic              dmaclr_int,
    input  logic              cmd_in_pin,
    input  logic              dat_in_pin,
    input  logic [5:0]        fn_intra,
    output logic [5:0]        intra_out,
    input  logic              fn_power,
    input  logic              fn_cmd_out,
    input  logic              fn_dat_out,
    output logic              power_pin,
    output logic              cmd_out_pin,
    output logic              dat_out_pin
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(IN_OFS);
    localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OUT_OFS);

    regsel_e          sel;
    ctrl_t            ctrl_q;
    logic [IN_W-1:0]  in_rd;
    logic [OUT_W-1:0] out_rd;
    prim_t            fn_prim;
    prim_t            prim_out;
    logic [DATA_W-1:0] rd_word;
    logic             wdata_unused;

    assign wdata_unused = ^bus_wdata[DATA_W-1:OUT_W];

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  sel = SEL_CTRL;
            A_IN:    sel = SEL_IN;
            A_OUT:   sel = SEL_OUT;
            default: sel = SEL_NONE;
        endcase
    end

    itest_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_wr && sel == SEL_CTRL),
        .wdata (bus_wdata[CTRL_W-1:0]),
        .q     (ctrl_q)
    );

    itest_in_path u_in (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_wr && sel == SEL_IN),
        .wbit    (bus_wdata[IN_CLR_BIT]),
        .test_en (ctrl_q.test_en),
        .clr_ext (dmaclr_ext),
        .cmd_pin (cmd_in_pin),
        .dat_pin (dat_in_pin),
        .clr_int (dmaclr_int),
        .rd_val  (in_rd)
    );

    assign fn_prim = '{power: fn_power, cmd_out: fn_cmd_out, dat_out: fn_dat_out};

    itest_out_path u_out (
        .clk       (clk),
        .rst       (rst),
        .we        (bus_wr && sel == SEL_OUT),
        .wdata     (bus_wdata[OUT_W-1:0]),
        .test_en   (ctrl_q.test_en),
        .fn_intra  (fn_intra),
        .fn_prim   (fn_prim),
        .intra_out (intra_out),
        .prim_out  (prim_out),
        .rd_val    (out_rd)
    );

    assign power_pin   = prim_out.power;
    assign cmd_out_pin = prim_out.cmd_out;
    assign dat_out_pin = prim_out.dat_out;

    assign test_en        = ctrl_q.test_en;
    assign fifo_test_mode = ctrl_q.fifo_test;
    assign reg_test_mode  = ctrl_q.reg_test;
    assign cmd_pad_en     = ctrl_q.cmd_pad_en;
    assign dat_pad_en     = ctrl_q.dat_pad_en;

    always_comb begin
        case (sel)
            SEL_CTRL: rd_word = DATA_W'(ctrl_q);
            SEL_IN:   rd_word = DATA_W'(in_rd);
            SEL_OUT:  rd_word = DATA_W'(out_rd);
            default:  rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= bus_rd ? rd_word : '0;
        end
    end

endmodule

// File: rtl/itest_regbank_chk.sv
module itest_regbank_chk #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int IN_OFS   = 'h104,
    parameter int CTRL_OFS = 'h100,
    parameter int OUT_OFS  = 'h108
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              test_en,
    input logic              reg_test_mode,
    input logic              cmd_pad_en,
    input logic              dat_pad_en,
    input logic              dmaclr_ext,
    input logic              dmaclr_int,
    input logic [5:0]        fn_intra,
    input logic [5:0]        intra_out,
    input logic              fn_power,
    input logic              fn_cmd_out,
    input logic              fn_dat_out,
    input logic              power_pin,
    input logic              cmd_out_pin,
    input logic              dat_out_pin
);

    a_r1_reset_ctrl: assert property (@(posedge clk)
        rst |=> (cmd_pad_en && dat_pad_en && !test_en && !reg_test_mode));

    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(CTRL_OFS))
        |=> (test_en == $past(bus_wdata[0]) && reg_test_mode == $past(bus_wdata[3])));

    a_r3_clr_pass: assert property (@(posedge clk) disable iff (rst)
        !test_en |-> dmaclr_int == dmaclr_ext);

    a_r3_clr_forced: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(IN_OFS) && test_en)
        |=> dmaclr_int == $past(bus_wdata[0]));

    a_r6_pad_drive: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OUT_OFS) && test_en)
        |=> (power_pin == $past(bus_wdata[11]) && cmd_out_pin == $past(bus_wdata[10])
             && dat_out_pin == $past(bus_wdata[6])));

    a_r7_intra_drive: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OUT_OFS) && test_en)
        |=> intra_out == $past(bus_wdata[5:0]));

    a_r8_func_follow: assert property (@(posedge clk) disable iff (rst)
        !test_en |-> (intra_out == fn_intra && power_pin == fn_power
                      && cmd_out_pin == fn_cmd_out && dat_out_pin == fn_dat_out));

    a_r10_rdata_idle: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> bus_rdata == '0);

endmodule

bind itest_regbank itest_regbank_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .IN_OFS   (IN_OFS),
    .CTRL_OFS (CTRL_OFS),
    .OUT_OFS  (OUT_OFS)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rd        (bus_rd),
    .bus_rdata     (bus_rdata),
    .test_en       (test_en),
    .reg_test_mode (reg_test_mode),
    .cmd_pad_en    (cmd_pad_en),
    .dat_pad_en    (dat_pad_en),
    .dmaclr_ext    (dmaclr_ext),
    .dmaclr_int    (dmaclr_int),
    .fn_intra      (fn_intra),
    .intra_out     (intra_out),
    .fn_power      (fn_power),
    .fn_cmd_out    (fn_cmd_out),
    .fn_dat_out    (fn_dat_out),
    .power_pin     (power_pin),
    .cmd_out_pin   (cmd_out_pin),
    .dat_out_pin   (dat_out_pin)
);

// File: tb/test_itest_regbank.sv
module test_itest_regbank;

    localparam logic [11:0] O_CTRL = 12'h100;
    localparam logic [11:0] O_IN   = 12'h104;
    localparam logic [11:0] O_OUT  = 12'h108;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        test_en;
    logic [1:0]  fifo_test_mode;
    logic        reg_test_mode, cmd_pad_en, dat_pad_en;
    logic        dmaclr_ext = 1'b0;
    logic        dmaclr_int;
    logic        cmd_in_pin = 1'b0, dat_in_pin = 1'b0;
    logic [5:0]  fn_intra = '0;
    logic [5:0]  intra_out;
    logic        fn_power = 1'b0, fn_cmd_out = 1'b0, fn_dat_out = 1'b0;
    logic        power_pin, cmd_out_pin, dat_out_pin;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    itest_regbank i_itest_regbank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .test_en(test_en), .fifo_test_mode(fifo_test_mode),
        .reg_test_mode(reg_test_mode), .cmd_pad_en(cmd_pad_en),
        .dat_pad_en(dat_pad_en), .dmaclr_ext(dmaclr_ext), .dmaclr_int(dmaclr_int),
        .cmd_in_pin(cmd_in_pin), .dat_in_pin(dat_in_pin), .fn_intra(fn_intra),
        .intra_out(intra_out), .fn_power(fn_power), .fn_cmd_out(fn_cmd_out),
        .fn_dat_out(fn_dat_out), .power_pin(power_pin), .cmd_out_pin(cmd_out_pin),
        .dat_out_pin(dat_out_pin)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        v        = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 pad enables", {30'd0, dat_pad_en, cmd_pad_en}, 32'h3);
        check("R1 other ctrl outputs", {28'd0, fifo_test_mode, reg_test_mode, test_en}, 32'h0);
        rd(O_CTRL, v); check("R1 ctrl read", v, 32'h30);
        rd(O_IN, v);   check("R1 in read", v, 32'h0);
        rd(O_OUT, v);  check("R1 out read", v, 32'h0);
    endtask

    task automatic t_ctrl_rw();
        logic [31:0] v;
        wr(O_CTRL, 32'hFFFF_FFFF);
        rd(O_CTRL, v); check("R2 all-ones ctrl", v, 32'h3F);
        check("R2 fifo field", {30'd0, fifo_test_mode}, 32'h3);
        wr(O_CTRL, 32'h0000_000A);
        rd(O_CTRL, v); check("R2 pattern ctrl", v, 32'h0A);
        check("R2 fields", {26'd0, dat_pad_en, cmd_pad_en, reg_test_mode, fifo_test_mode, test_en},
              32'h0A);
    endtask

    task automatic t_clr_path();
        logic [31:0] v;
        wr(O_CTRL, 32'h30);
        wr(O_IN, 32'h1);
        dmaclr_ext = 1'b0;
        #1 check("R3 pass ext=0", {31'd0, dmaclr_int}, 32'h0);
        rd(O_IN, v); check("R4 read mux out 0", v, 32'h0);
        dmaclr_ext = 1'b1;
        #1 check("R3 pass ext=1", {31'd0, dmaclr_int}, 32'h1);
        rd(O_IN, v); check("R4 read mux out 1", v, 32'h1);
        wr(O_CTRL, 32'h31);
        dmaclr_ext = 1'b0;
        #1 check("R3 forced stored 1", {31'd0, dmaclr_int}, 32'h1);
        dmaclr_ext = 1'b1;
        wr(O_IN, 32'h0);
        check("R3 forced stored 0", {31'd0, dmaclr_int}, 32'h0);
        rd(O_IN, v); check("R4 read forced value", v, 32'h0);
        dmaclr_ext = 1'b0;
    endtask

    task automatic t_in_pins();
        logic [31:0] v;
        cmd_in_pin = 1'b1; dat_in_pin = 1'b0;
        rd(O_IN, v); check("R5 cmd pin", v, 32'h20);
        cmd_in_pin = 1'b0; dat_in_pin = 1'b1;
        rd(O_IN, v); check("R5 dat pin", v, 32'h02);
        dat_in_pin = 1'b0;
        wr(O_IN, 32'hFFFF_FFFE);
        rd(O_IN, v); check("R5 reserved ignored", v, 32'h0);
    endtask

    task automatic t_out_prim();
        logic [31:0] v;
        wr(O_CTRL, 32'h31);
        wr(O_OUT, 32'hC40);
        check("R6 pads driven", {29'd0, power_pin, cmd_out_pin, dat_out_pin}, 32'h7);
        rd(O_OUT, v); check("R6 pad readback", v, 32'hC40);
        wr(O_OUT, 32'h400);
        check("R6 pads pattern", {29'd0, power_pin, cmd_out_pin, dat_out_pin}, 32'h2);
        wr(O_CTRL, 32'h30);
        fn_power = 1'b1;
        #1 check("R8 pads functional", {29'd0, power_pin, cmd_out_pin, dat_out_pin}, 32'h4);
        rd(O_OUT, v); check("R6 readback stored not pin", v, 32'h400);
        fn_power = 1'b0;
    endtask

    task automatic t_out_intra();
        logic [31:0] v;
        wr(O_CTRL, 32'h31);
        fn_intra = 6'h15;
        wr(O_OUT, 32'h2A);
        check("R7 intra driven", {26'd0, intra_out}, 32'h2A);
        rd(O_OUT, v); check("R7 intra readback", v, 32'h2A);
        wr(O_OUT, 32'hFFF);
        rd(O_OUT, v); check("R7 reserved 9:7", v, 32'hC7F);
        check("R7 all intra", {26'd0, intra_out}, 32'h3F);
    endtask

    task automatic t_retain();
        logic [31:0] v;
        wr(O_CTRL, 32'h30);
        check("R8 intra functional", {26'd0, intra_out}, 32'h15);
        check("R8 pads functional 0", {29'd0, power_pin, cmd_out_pin, dat_out_pin}, 32'h0);
        rd(O_OUT, v); check("R8 readback mix", v, 32'hC55);
        wr(O_CTRL, 32'h31);
        check("R8 retained intra", {26'd0, intra_out}, 32'h3F);
        check("R8 retained pads", {29'd0, power_pin, cmd_out_pin, dat_out_pin}, 32'h7);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd(12'h000, v); check("R9 read 0x000", v, 32'h0);
        rd(12'h10C, v); check("R9 read 0x10C", v, 32'h0);
        rd(12'h200, v); check("R9 read 0x200", v, 32'h0);
        wr(12'h10C, 32'h0);
        wr(12'h000, 32'h0);
        rd(O_OUT, v);  check("R9 out unchanged", v, 32'hC7F);
        rd(O_CTRL, v); check("R9 ctrl unchanged", v, 32'h31);
    endtask

    task automatic t_read_timing();
        logic [31:0] v;
        rd(O_CTRL, v); check("R10 data after read", v, 32'h31);
        @(negedge clk); check("R10 zero after idle", bus_rdata, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl_rw();
        t_clr_path();
        t_in_pins();
        t_out_prim();
        t_out_intra();
        t_retain();
        t_unmapped();
        t_read_timing();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule